// File: doc/BRIEF.md
# Flip-and-write line encoder for phase-change memory

This block prepares one memory line for a phase-change memory write so that as few cells as possible change state. The line is cut into equal segments, and each segment is stored next to one flip cell. For every segment the encoder compares the new data with the segment's current stored contents, flip cell included. It then picks whichever of the two encodings, plain or inverted, changes fewer cells. The result is the encoded line to store, the new flip cells, and a per-cell write mask that selects only the cells whose value really changes.

Each segment occupies one power-limited write slot, so the encoder also reports how many slots the write needs and raises a write enable only when at least one cell changes. A separate combinational decode path turns a stored line and its flip cells back into plain data.

The write path is a single registered stage with valid/ready on both sides. An input beat is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The result appears one cycle after acceptance. While `out_valid` is high and `out_ready` is low, every output of the stage stays frozen and no new beat is accepted.

Top module: `fnw_line_encoder`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: For each segment, the kept count is the number of data bits where the new data differs from the stored code, plus one if the stored flip cell is 1. The segment is inverted (new flip = 1) exactly when this count is greater than SEG_W/2. A tie keeps it plain (flip = 0).
- R3: The encoded segment `out_code` equals the new data when its flip is 0 and the bitwise inverse of the new data when its flip is 1.
- R4: `out_mask` bit i is 1 exactly when `out_code` bit i differs from the stored code bit i. `out_flip_mask` bit s is 1 exactly when the new flip of segment s differs from its stored flip.
- R5: In every segment the number of set bits in `out_mask`, plus its `out_flip_mask` bit, is at most SEG_W/2, so one write slot always suffices.
- R6: `out_slots` equals the number of segments with at least one set mask or flip-mask bit. `out_wen` is 1 exactly when `out_slots` is nonzero, and a line with no changed cell reports zero slots with all masks clear.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs of the write path hold their values.
- R8: A beat accepted on an edge is presented on the outputs right after that edge, with `out_valid` high.
- R9: `dec_data` segment s equals `dec_code` segment s XOR the replicated bit s of `dec_flip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | New write beat present |
| in_ready | output | 1 | Encoder can take a beat |
| in_data | input | LINE_W | New plain line data |
| in_old_code | input | LINE_W | Line code currently stored in the cells |
| in_old_flip | input | NSEG | Flip cells currently stored, bit s for segment s |
| out_valid | output | 1 | Encoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | LINE_W | Encoded line to store |
| out_flip | output | NSEG | New flip cells |
| out_mask | output | LINE_W | Per data cell write select |
| out_flip_mask | output | NSEG | Per flip cell write select |
| out_slots | output | SLOT_W | Number of write slots the write needs |
| out_wen | output | 1 | At least one cell changes |
| dec_code | input | LINE_W | Stored line code to decode |
| dec_flip | input | NSEG | Stored flip cells to decode |
| dec_data | output | LINE_W | Recovered plain data |

## Verification
The hardest case to reach is a segment whose kept count sits exactly at SEG_W/2, especially when the stored flip cell is part of that count. This is the point where the tie rule and the one-slot bound meet. The bench uses a small configuration with four-bit segments and sweeps every combination of new data, stored code and stored flip in each segment. It rotates the combinations across segments so that ties, full inversions and unchanged segments all appear in the same line. Back-pressure is reached by holding `out_ready` low while a second beat is offered.

// File: rtl/fnw_pkg.sv
package fnw_pkg;
  parameter int unsigned DEF_LINE_W = 512;
  parameter int unsigned DEF_SEG_W  = 128;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/fnw_popcount.sv
module fnw_popcount #(
  parameter int unsigned W   = 128,
  localparam int unsigned CW = fnw_pkg::cnt_width(W)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/fnw_segment.sv
module fnw_segment #(
  parameter int unsigned SEG_W = 128,
  localparam int unsigned CW   = fnw_pkg::cnt_width(SEG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] new_data,
  input  logic [SEG_W-1:0] old_code,
  input  logic             old_flip,
  output logic [SEG_W-1:0] code,
  output logic             flip,
  output logic [SEG_W-1:0] mask,
  output logic             flip_mask,
  output logic             touched
);
  localparam int unsigned HALF = SEG_W / 2;
  localparam int unsigned PCW  = fnw_pkg::cnt_width(SEG_W);

  logic [PCW-1:0] diff_cnt;
  logic [CW-1:0]  keep_cnt;
  logic [PCW-1:0] mask_cnt;

  fnw_popcount #(.W(SEG_W)) u_diff (.bits(new_data ^ old_code), .count(diff_cnt));

  // cells changed if the segment is written plain, flip cell included
  assign keep_cnt = CW'(diff_cnt) + CW'(old_flip);
  assign flip      = (keep_cnt > CW'(HALF));
  assign code      = flip ? ~new_data : new_data;
  assign mask      = code ^ old_code;
  assign flip_mask = flip ^ old_flip;
  assign touched   = (|mask) | flip_mask;

  fnw_popcount #(.W(SEG_W)) u_mcnt (.bits(mask), .count(mask_cnt));

  // R5: the chosen encoding fits within one write slot budget
  a_r5_seg_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(mask_cnt) + CW'(flip_mask)) <= CW'(HALF));
endmodule

// File: rtl/fnw_decode.sv
module fnw_decode #(
  parameter int unsigned LINE_W = 512,
  parameter int unsigned SEG_W  = 128,
  localparam int unsigned NSEG  = LINE_W / SEG_W
) (
  input  logic [LINE_W-1:0] code,
  input  logic [NSEG-1:0]   flip,
  output logic [LINE_W-1:0] data
);
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign data[s*SEG_W +: SEG_W] = code[s*SEG_W +: SEG_W] ^ {SEG_W{flip[s]}};
  end
endmodule

// File: rtl/fnw_line_encoder.sv
module fnw_line_encoder #(
  parameter int unsigned LINE_W = fnw_pkg::DEF_LINE_W,
  parameter int unsigned SEG_W  = fnw_pkg::DEF_SEG_W,
  localparam int unsigned NSEG  = LINE_W / SEG_W,
  localparam int unsigned SLOT_W = fnw_pkg::cnt_width(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LINE_W-1:0] in_data,
  input  logic [LINE_W-1:0] in_old_code,
  input  logic [NSEG-1:0]   in_old_flip,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_code,
  output logic [NSEG-1:0]   out_flip,
  output logic [LINE_W-1:0] out_mask,
  output logic [NSEG-1:0]   out_flip_mask,
  output logic [SLOT_W-1:0] out_slots,
  output logic              out_wen,
  input  logic [LINE_W-1:0] dec_code,
  input  logic [NSEG-1:0]   dec_flip,
  output logic [LINE_W-1:0] dec_data
);
  logic [LINE_W-1:0] nx_code, nx_mask;
  logic [NSEG-1:0]   nx_flip, nx_fmask, nx_touch;
  logic [SLOT_W-1:0] nx_slots;
  logic              take;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    fnw_segment #(.SEG_W(SEG_W)) u_seg (
      .clk       (clk),
      .rst_n     (rst_n),
      .new_data  (in_data[s*SEG_W +: SEG_W]),
      .old_code  (in_old_code[s*SEG_W +: SEG_W]),
      .old_flip  (in_old_flip[s]),
      .code      (nx_code[s*SEG_W +: SEG_W]),
      .flip      (nx_flip[s]),
      .mask      (nx_mask[s*SEG_W +: SEG_W]),
      .flip_mask (nx_fmask[s]),
      .touched   (nx_touch[s])
    );
  end

  always_comb begin
    nx_slots = '0;
    for (int s = 0; s < NSEG; s++) begin
      nx_slots = nx_slots + SLOT_W'(nx_touch[s]);
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_code      <= '0;
      out_flip      <= '0;
      out_mask      <= '0;
      out_flip_mask <= '0;
      out_slots     <= '0;
      out_wen       <= 1'b0;
    end else begin
      if (take) begin
        out_valid     <= 1'b1;
        out_code      <= nx_code;
        out_flip      <= nx_flip;
        out_mask      <= nx_mask;
        out_flip_mask <= nx_fmask;
        out_slots     <= nx_slots;
        out_wen       <= |nx_touch;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  fnw_decode #(.LINE_W(LINE_W), .SEG_W(SEG_W)) u_dec (
    .code (dec_code),
    .flip (dec_flip),
    .data (dec_data)
  );

  // R7: a stalled result stays frozen
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_mask)
      && $stable(out_flip) && $stable(out_slots) && $stable(out_wen)));

  // R8: an accepted beat shows up on the next edge
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6: no write enable means no selected cell
  a_r6_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wen) |-> (out_mask == '0 && out_flip_mask == '0 && out_slots == '0));

  // R6: slot count bounded by the segment count
  a_r6_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_slots <= SLOT_W'(NSEG)));
endmodule

// File: tb/tb_fnw_line_encoder.sv
module tb_fnw_line_encoder;
  localparam int LW = 16;
  localparam int SW = 4;
  localparam int NS = LW / SW;
  localparam int SLW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_wen;
  logic [LW-1:0] in_data = '0, in_old_code = '0, dec_code = '0;
  logic [NS-1:0] in_old_flip = '0, dec_flip = '0;
  logic [LW-1:0] out_code, out_mask, dec_data;
  logic [NS-1:0] out_flip, out_flip_mask;
  logic [SLW-1:0] out_slots;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  fnw_line_encoder #(.LINE_W(LW), .SEG_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_old_code(in_old_code), .in_old_flip(in_old_flip),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_flip(out_flip), .out_mask(out_mask), .out_flip_mask(out_flip_mask),
    .out_slots(out_slots), .out_wen(out_wen), .dec_code(dec_code),
    .dec_flip(dec_flip), .dec_data(dec_data)
  );

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected encoding computed from the requirement arithmetic
  logic [LW-1:0] e_code, e_mask;
  logic [NS-1:0] e_flip, e_fmask;
  int e_slots;

  task automatic model(input logic [LW-1:0] d, input logic [LW-1:0] oc, input logic [NS-1:0] of);
    e_slots = 0;
    for (int s = 0; s < NS; s++) begin
      int keep = 0;
      int chg = 0;
      for (int b = 0; b < SW; b++) keep += (d[s*SW+b] != oc[s*SW+b]) ? 1 : 0;
      keep += of[s] ? 1 : 0;
      e_flip[s] = (2 * keep > SW);
      for (int b = 0; b < SW; b++) begin
        e_code[s*SW+b] = d[s*SW+b] ^ e_flip[s];
        e_mask[s*SW+b] = e_code[s*SW+b] ^ oc[s*SW+b];
        chg += e_mask[s*SW+b] ? 1 : 0;
      end
      e_fmask[s] = e_flip[s] ^ of[s];
      chg += e_fmask[s] ? 1 : 0;
      if (2 * chg > SW) begin
        errors++;
        checks++;
        $display("FAIL R5 model count actual=%0d expected<=%0d", chg, SW / 2);
      end
      if (chg != 0) e_slots++;
    end
  endtask

  task automatic send_check(input logic [LW-1:0] d, input logic [LW-1:0] oc, input logic [NS-1:0] of);
    @(negedge clk);
    in_data = d; in_old_code = oc; in_old_flip = of;
    in_valid = 1'b1; out_ready = 1'b1;
    model(d, oc, of);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 valid", LW'(out_valid), LW'(1));
    chk("R2 flip", LW'(out_flip), LW'(e_flip));
    chk("R3 code", out_code, e_code);
    chk("R4 mask", out_mask, e_mask);
    chk("R4 flipmask", LW'(out_flip_mask), LW'(e_fmask));
    chk("R6 slots", LW'(out_slots), LW'(e_slots));
    chk("R6 wen", LW'(out_wen), LW'(e_slots != 0));
    dec_code = out_code; dec_flip = out_flip;
    #1;
    chk("R9 decode", dec_data, d);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", LW'(out_valid), LW'(0));
    chk("R1 in_ready", LW'(in_ready), LW'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", LW'(out_valid), LW'(0));

    // R6: unchanged line, zero slots
    send_check(16'h5A3C, 16'hA53C, 4'b1100);
    chk("R6 zero slots", LW'(out_slots), LW'(0));
    // R2: tie keeps plain (2 of 4 differ, flip 0)
    send_check(16'h0003, 16'h0000, 4'b0000);
    chk("R2 tie plain", LW'(out_flip[0]), LW'(0));
    // R2: tie reached via stored flip (1 differs + flip 1 = 2)
    send_check(16'h0001, 16'h0000, 4'b0001);
    chk("R2 tie with flip", LW'(out_flip[0]), LW'(0));
    // R2: 3 of 4 cells change -> invert
    send_check(16'h0007, 16'h0000, 4'b0000);
    chk("R2 invert", LW'(out_flip[0]), LW'(1));

    // exhaustive per segment sweep, rotated across segments
    for (int i = 0; i < 512; i++) begin
      logic [LW-1:0] d, oc;
      logic [NS-1:0] of;
      for (int k = 0; k < NS; k++) begin
        int c = (i + k * 131) % 512;
        d[k*SW +: SW]  = SW'(c);
        oc[k*SW +: SW] = SW'(c >> 4);
        of[k]          = c[8];
      end
      send_check(d, oc, of);
    end

    // R7: back-pressure
    @(negedge clk);
    model(16'h1234, 16'h0000, 4'b0000);
    in_data = 16'h1234; in_old_code = '0; in_old_flip = '0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk("R8 stalled valid", LW'(out_valid), LW'(1));
    chk("R7 ready low", LW'(in_ready), LW'(0));
    in_data = 16'hFFFF;
    @(negedge clk);
    chk("R7 hold code", out_code, e_code);
    chk("R7 ready low 2", LW'(in_ready), LW'(0));
    out_ready = 1'b1;
    #1;
    chk("R7 ready follows out_ready", LW'(in_ready), LW'(1));
    model(16'hFFFF, 16'h0000, 4'b0000);
    @(negedge clk);
    chk("R7 second beat code", out_code, e_code);
    chk("R7 second beat flip", LW'(out_flip), LW'(e_flip));
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 drained", LW'(out_valid), LW'(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule